// File: doc/BRIEF.md
# Third-Order Fractional-N Interpolator

This block produces the per-cycle divide-ratio correction for a fractional-N frequency divider. It advances once on every phase-detector reference clock. Each step yields a small signed offset that is added to the integer divide value. Over time, the mean of that offset equals FRAC/MOD, so the channel step is the reference rate divided by MOD. The noise-shaping core is three cascaded accumulators that wrap at MOD. Their carries are merged through first and second differences into a single offset in the range -3 to +4.

Software programs the block through a single-cycle write strobe with a 2-bit address. The programmable values are the fraction, the modulus, a seed for the first accumulator, and a control word. The control word holds two bits. One enables a pseudo-random one-LSB dither, which spreads the spurious tones into noise. The other decides whether a write to the fraction restarts the modulator from its seed. Restarting from the seed makes the spur pattern repeatable from one write to the next. A flag reports a modulus that is illegal for the current mode.

Top module: `frac_sdm3`

## Requirements
- R1: During and after reset, `ofs` is 0 and `cfg_bad` is 0, with FRAC=0, MOD=2, seed=0, dither off and restart-on-write on. All three accumulators, the difference delays and the dither register (set to 1) start from their reset state.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` at the next rising edge. The address selects the target: 0 is FRAC, 1 is MOD, 2 is the seed, 3 is control. In the control word, bit 0 enables dither and bit 1 set to 1 disables restart-on-write.
- R3: On each clock edge, stage 1 adds FRAC plus the dither bit to its accumulator. Stage 2 adds stage 1's new residue to its own accumulator, and stage 3 adds stage 2's new residue to its own. Any stage whose sum is at least MOD subtracts MOD and raises its carry. The registered output is c1 + c2 − c2' + c3 − 2·c3' + c3'', where each prime marks a one-step delay. It is a 4-bit two's-complement value between -3 and +4.
- R4: With dither off, the sum of `ofs` over any whole repeat period P equals P·FRAC/MOD exactly.
- R5: With dither off, the output repeats with period MOD. The period is 2·MOD when MOD is even but not a multiple of 3, 3·MOD when MOD is a multiple of 3 but odd, and 6·MOD when MOD is a multiple of 6.
- R6: A FRAC write while restart-on-write is on does the following at that edge: stage 1 is loaded with the seed, stages 2 and 3 are cleared, the difference delays are cleared, `ofs` is cleared and the dither register is set to 1. The next edge computes the first step with the new FRAC. Two such writes with equal settings produce identical sequences.
- R7: A FRAC write while restart-on-write is off does not disturb the accumulators. That edge still steps with the old FRAC, and the new FRAC applies from the following edge.
- R8: With dither on, the dither bit is bit 20 of a 21-bit shift register. On each step the register shifts left and takes in bit 20 XOR bit 18, which gives a maximal sequence. That bit is added to stage 1's input. With dither off the bit is 0 and the register holds.
- R9: `cfg_bad` is 1 exactly while MOD < 2, or while dither is on and MOD < 50. It follows the stored registers and changes right after the write edge.
- R10: Writes to MOD, the seed or control do not restart the modulator. The edge that stores them still steps with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector reference clock; one modulator step per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Single-cycle register write strobe |
| cfg_addr | input | 2 | Register select: 0 FRAC, 1 MOD, 2 seed, 3 control |
| cfg_wdata | input | 12 | Write data (MOD_W bits) |
| ofs | output | 4 | Signed divide-ratio offset, -3 to +4 |
| cfg_bad | output | 1 | Modulus illegal for the current mode |

## Verification
The bench keeps the default 12-bit modulus field, the 21-bit dither register and a dither floor of 50. Because of these defaults it can program a small modulus such as 7, 10, 9 and 12. Each of these falls in a different divisibility class, and its full period of at most 72 steps can be recorded twice and checked for both exact sum and repetition. With dither on, a modulus of 100 exercises the pseudo-random path over several thousand steps. Moving the modulus to 40 and to 1 crosses both legality limits.

// File: rtl/frac_sdm3_pkg.sv
package frac_sdm3_pkg;

   typedef enum logic [1:0] {
      CFG_FRAC  = 2'd0,
      CFG_MOD   = 2'd1,
      CFG_PHASE = 2'd2,
      CFG_CTRL  = 2'd3
   } cfg_addr_e;

   localparam int CTRL_DITHER_BIT = 0;
   localparam int CTRL_HOLD_BIT   = 1;
   localparam int SDM_STAGES      = 3;

endpackage

// File: rtl/sdm_cfg_regs.sv
module sdm_cfg_regs
   import frac_sdm3_pkg::*;
#(
   parameter int MOD_W        = 12,
   parameter int DITH_MIN_MOD = 50,
   parameter int MOD_RST      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_addr,
   input  logic [MOD_W-1:0] cfg_wdata,
   output logic [MOD_W-1:0] frac_q,
   output logic [MOD_W-1:0] mod_q,
   output logic [MOD_W-1:0] phase_q,
   output logic             dith_q,
   output logic             hold_q,
   output logic             reload,
   output logic             cfg_bad
);
   localparam logic [MOD_W-1:0] DMIN   = MOD_W'(DITH_MIN_MOD);
   localparam logic [MOD_W-1:0] ABSMIN = MOD_W'(2);
   localparam logic [MOD_W-1:0] MRST   = MOD_W'(MOD_RST);

   cfg_addr_e sel;
   assign sel = cfg_addr_e'(cfg_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frac_q  <= '0;
         mod_q   <= MRST;
         phase_q <= '0;
         dith_q  <= 1'b0;
         hold_q  <= 1'b0;
      end else if (cfg_we) begin
         case (sel)
            CFG_FRAC:  frac_q  <= cfg_wdata;
            CFG_MOD:   mod_q   <= cfg_wdata;
            CFG_PHASE: phase_q <= cfg_wdata;
            CFG_CTRL: begin
               dith_q <= cfg_wdata[CTRL_DITHER_BIT];
               hold_q <= cfg_wdata[CTRL_HOLD_BIT];
            end
            default: ;
         endcase
      end
   end

   assign reload  = cfg_we && (sel == CFG_FRAC) && !hold_q;
   assign cfg_bad = (mod_q < ABSMIN) || (dith_q && (mod_q < DMIN));

endmodule

// File: rtl/sdm_mod_acc.sv
module sdm_mod_acc #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic [W:0]   inc,
   input  logic [W-1:0] modv,
   output logic [W-1:0] acc_q,
   output logic [W-1:0] acc_nx,
   output logic         carry
);
   logic [W+1:0] sum;
   logic [W+1:0] red;

   always_comb begin
      sum   = {2'b00, acc_q} + {1'b0, inc};
      carry = (sum >= {2'b00, modv});
      red   = carry ? (sum - {2'b00, modv}) : sum;
      acc_nx = red[W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    acc_q <= '0;
      else if (load) acc_q <= seed;
      else           acc_q <= acc_nx;
   end

endmodule

// File: rtl/sdm_dither.sv
module sdm_dither #(
   parameter bit EN  = 1'b1,
   parameter int LW  = 21,
   parameter int TAP = 19
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          run,
   output logic          dbit,
   output logic [LW-1:0] state
);
   localparam logic [LW-1:0] SEED = LW'(1);

   generate
      if (EN) begin : g_lfsr
         logic [LW-1:0] sr;
         logic          fb;
         assign fb = sr[LW-1] ^ sr[TAP-1];
         always_ff @(posedge clk) begin
            if (!rst_n)    sr <= SEED;
            else if (load) sr <= SEED;
            else if (run)  sr <= {sr[LW-2:0], fb};
         end
         assign dbit  = run & sr[LW-1];
         assign state = sr;
      end else begin : g_none
         assign dbit  = 1'b0;
         assign state = SEED;
      end
   endgenerate

endmodule

// File: rtl/sdm_mash_comb.sv
module sdm_mash_comb #(
   parameter int OUT_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [2:0]              cy,
   output logic signed [OUT_W-1:0] ofs
);
   logic c2_d, c3_d, c3_dd;
   logic [OUT_W-1:0] y;

   always_comb begin
      y = OUT_W'(cy[0])
        + OUT_W'(cy[1]) - OUT_W'(c2_d)
        + OUT_W'(cy[2]) - (OUT_W'(c3_d) << 1) + OUT_W'(c3_dd);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         c2_d  <= 1'b0;
         c3_d  <= 1'b0;
         c3_dd <= 1'b0;
         ofs   <= '0;
      end else begin
         c2_d  <= cy[1];
         c3_d  <= cy[2];
         c3_dd <= c3_d;
         ofs   <= $signed(y);
      end
   end

endmodule

// File: rtl/frac_sdm3.sv
module frac_sdm3
   import frac_sdm3_pkg::*;
#(
   parameter int MOD_W        = 12,
   parameter bit DITHER_EN    = 1'b1,
   parameter int LFSR_W       = 21,
   parameter int LFSR_TAP     = 19,
   parameter int DITH_MIN_MOD = 50,
   parameter int MOD_RST      = 2,
   parameter int OUT_W        = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [1:0]              cfg_addr,
   input  logic [MOD_W-1:0]        cfg_wdata,
   output logic signed [OUT_W-1:0] ofs,
   output logic                    cfg_bad
);
   localparam int NSTG = SDM_STAGES;

   generate
      if (MOD_W < 7)                   begin : g_e0 $error("MOD_W too small for dither floor"); end
      if (OUT_W < 4)                   begin : g_e1 $error("OUT_W must hold -3..+4"); end
      if (LFSR_TAP >= LFSR_W || LFSR_TAP < 1) begin : g_e2 $error("LFSR_TAP out of range"); end
      if (DITH_MIN_MOD >= (1 << MOD_W)) begin : g_e3 $error("DITH_MIN_MOD exceeds modulus field"); end
   endgenerate

   logic [MOD_W-1:0] frac_q, mod_q, phase_q;
   logic             dith_q, hold_q, reload;
   logic             dbit;
   logic [LFSR_W-1:0] lfsr_st;

   sdm_cfg_regs #(
      .MOD_W(MOD_W), .DITH_MIN_MOD(DITH_MIN_MOD), .MOD_RST(MOD_RST)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .frac_q(frac_q), .mod_q(mod_q),
      .phase_q(phase_q), .dith_q(dith_q), .hold_q(hold_q),
      .reload(reload), .cfg_bad(cfg_bad)
   );

   sdm_dither #(
      .EN(DITHER_EN), .LW(LFSR_W), .TAP(LFSR_TAP)
   ) u_dith (
      .clk(clk), .rst_n(rst_n), .load(reload), .run(dith_q),
      .dbit(dbit), .state(lfsr_st)
   );

   logic [MOD_W-1:0] acc_q  [NSTG];
   logic [MOD_W-1:0] acc_nx [NSTG];
   logic [MOD_W:0]   inc    [NSTG];
   logic [NSTG-1:0]  cy;

   generate
      for (genvar k = 0; k < NSTG; k++) begin : g_stg
         if (k == 0) begin : g_head
            assign inc[k] = {1'b0, frac_q} + {{MOD_W{1'b0}}, dbit};
         end else begin : g_tail
            assign inc[k] = {1'b0, acc_nx[k-1]};
         end
         sdm_mod_acc #(.W(MOD_W)) u_acc (
            .clk(clk), .rst_n(rst_n), .load(reload),
            .seed((k == 0) ? phase_q : '0),
            .inc(inc[k]), .modv(mod_q),
            .acc_q(acc_q[k]), .acc_nx(acc_nx[k]), .carry(cy[k])
         );
      end
   endgenerate

   sdm_mash_comb #(.OUT_W(OUT_W)) u_comb (
      .clk(clk), .rst_n(rst_n), .load(reload), .cy(cy), .ofs(ofs)
   );

endmodule

// File: rtl/frac_sdm3_chk.sv
module frac_sdm3_chk #(
   parameter int OUT_W  = 4,
   parameter int LFSR_W = 21
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cfg_we,
   input logic                    reload,
   input logic                    dith_on,
   input logic [LFSR_W-1:0]       lfsr,
   input logic signed [OUT_W-1:0] ofs,
   input logic                    cfg_bad
);
   // R6: a restart leaves a zero offset on the following cycle
   a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (ofs == '0));

   // R3: offset stays inside the third-order output range
   a_r3_ofs_range: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(ofs) >= -3) && (int'(ofs) <= 4));

   // R9: the legality flag can only rise after a register write
   a_r9_bad_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_bad) |-> $past(cfg_we));

   // R8: the dither register never locks up at zero
   a_r8_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
      dith_on |-> (lfsr != '0));

endmodule

bind frac_sdm3 frac_sdm3_chk #(.OUT_W(OUT_W), .LFSR_W(LFSR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .reload(reload),
   .dith_on(dith_q), .lfsr(lfsr_st), .ofs(ofs), .cfg_bad(cfg_bad)
);

// File: tb/frac_sdm3_test.sv
`timescale 1ns/1ps
module frac_sdm3_test;
   localparam int MW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic we = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [MW-1:0] wd = '0;
   logic signed [3:0] ofs;
   logic bad;

   always #2.5 clk = ~clk;

   frac_sdm3 uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_addr(addr),
      .cfg_wdata(wd), .ofs(ofs), .cfg_bad(bad)
   );

   int total = 0;
   int nfail = 0;

   // behavioural reference state
   int m_frac, m_mod, m_phase, m_dith, m_hold;
   int m_a1, m_a2, m_a3, m_c2d, m_c3d, m_c3dd, m_y;
   int m_lfsr;
   int seq[$];
   bit rec = 0;

   task automatic check(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic m_reset();
      m_frac = 0; m_mod = 2; m_phase = 0; m_dith = 0; m_hold = 0;
      m_a1 = 0; m_a2 = 0; m_a3 = 0; m_c2d = 0; m_c3d = 0; m_c3dd = 0;
      m_y = 0; m_lfsr = 1;
   endtask

   function automatic int m_bad();
      return ((m_mod < 2) || (m_dith != 0 && m_mod < 50)) ? 1 : 0;
   endfunction

   task automatic m_step(bit w, int a, int d);
      int dv, s1, s2, s3, c1, c2, c3, fb;
      dv = (m_dith != 0) ? ((m_lfsr >> 20) & 1) : 0;
      s1 = m_a1 + m_frac + dv; c1 = (s1 >= m_mod) ? 1 : 0; if (c1 != 0) s1 -= m_mod;
      s2 = m_a2 + s1;          c2 = (s2 >= m_mod) ? 1 : 0; if (c2 != 0) s2 -= m_mod;
      s3 = m_a3 + s2;          c3 = (s3 >= m_mod) ? 1 : 0; if (c3 != 0) s3 -= m_mod;
      m_y = c1 + c2 - m_c2d + c3 - 2 * m_c3d + m_c3dd;
      m_c3dd = m_c3d; m_c3d = c3; m_c2d = c2;
      m_a1 = s1; m_a2 = s2; m_a3 = s3;
      if (m_dith != 0) begin
         fb = ((m_lfsr >> 20) ^ (m_lfsr >> 18)) & 1;
         m_lfsr = ((m_lfsr << 1) | fb) & 32'h1F_FFFF;
      end
      if (w) begin
         case (a)
            0: begin
               if (m_hold == 0) begin
                  m_a1 = m_phase; m_a2 = 0; m_a3 = 0;
                  m_c2d = 0; m_c3d = 0; m_c3dd = 0; m_y = 0; m_lfsr = 1;
               end
               m_frac = d;
            end
            1: m_mod = d;
            2: m_phase = d;
            default: begin m_dith = d & 1; m_hold = (d >> 1) & 1; end
         endcase
      end
   endtask

   task automatic cyc(bit w, int a, int d);
      we = w; addr = a[1:0]; wd = d[MW-1:0];
      m_step(w, a, d);
      @(negedge clk);
      we = 1'b0;
      check(int'(ofs) == m_y, "R3 per-cycle offset", int'(ofs), m_y);
      check(int'(bad) == m_bad(), "R9 legality flag", int'(bad), m_bad());
      if (rec) seq.push_back(int'(ofs));
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 0, 0);
   endtask

   task automatic run_period(int md, int fr, int ph, int p);
      int sum, ok, lmin;
      cyc(1'b1, 3, 0);
      cyc(1'b1, 1, md);
      cyc(1'b1, 2, ph);
      cyc(1'b1, 0, fr);
      check(int'(ofs) == 0, "R6 restart clears offset", int'(ofs), 0);
      idle(4);
      seq.delete(); rec = 1; idle(2 * p); rec = 0;
      ok = 1;
      for (int i = 0; i < p; i++) if (seq[i] != seq[i + p]) ok = 0;
      check(ok == 1, "R5 sequence repeats at rule period", ok, 1);
      sum = 0;
      for (int i = 0; i < p; i++) sum += seq[i];
      check(sum * md == p * fr, "R4 period sum times MOD", sum * md, p * fr);
      lmin = p;
      for (int l = 1; l <= p; l++) begin
         int good = 1;
         for (int i = 0; i < p; i++) if (seq[i] != seq[i + l]) good = 0;
         if (good == 1 && l < lmin) lmin = l;
      end
      check((p % lmin) == 0, "R5 measured period divides rule period", lmin, p);
   endtask

   initial begin : watchdog
      #(5.0 * 100000);
      total++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, nfail);
      $finish;
   end

   initial begin : main
      int a[$];
      int b[$];
      int same;
      m_reset();
      repeat (3) @(negedge clk);
      check(int'(ofs) == 0, "R1 offset in reset", int'(ofs), 0);
      check(int'(bad) == 0, "R1 flag in reset", int'(bad), 0);
      rst_n = 1'b1;
      idle(5);
      check(int'(ofs) == 0, "R1 idle default offset", int'(ofs), 0);

      // R5 / R4 divisibility classes (R2 address map used throughout)
      run_period(7, 3, 0, 7);
      run_period(10, 3, 0, 20);
      run_period(9, 4, 0, 27);
      run_period(12, 5, 0, 72);

      // R6 repeatability with a seed
      cyc(1'b1, 2, 5);
      cyc(1'b1, 0, 5);
      seq.delete(); rec = 1; idle(40); rec = 0; a = seq;
      idle(7);
      cyc(1'b1, 0, 5);
      seq.delete(); rec = 1; idle(40); rec = 0; b = seq;
      same = 1;
      for (int i = 0; i < 40; i++) if (a[i] != b[i]) same = 0;
      check(same == 1, "R6 equal seeds give equal sequences", same, 1);

      // R7 restart disabled: FRAC write keeps stepping
      cyc(1'b1, 3, 2);
      idle(3);
      cyc(1'b1, 0, 7);
      check(int'(ofs) == m_y, "R7 no restart on held write", int'(ofs), m_y);
      idle(30);

      // R10 other writes do not restart
      cyc(1'b1, 2, 3);
      check(int'(ofs) == m_y, "R10 seed write continues", int'(ofs), m_y);
      cyc(1'b1, 1, 11);
      check(int'(ofs) == m_y, "R10 modulus write continues", int'(ofs), m_y);
      idle(20);

      // R8 dither path
      cyc(1'b1, 3, 1);
      cyc(1'b1, 1, 100);
      cyc(1'b1, 2, 0);
      cyc(1'b1, 0, 37);
      idle(3000);
      check(int'(bad) == 0, "R9 dither with MOD 100 legal", int'(bad), 0);
      cyc(1'b1, 0, 37);
      check(int'(ofs) == 0, "R8 restart reseeds dither", int'(ofs), 0);
      idle(50);

      // R9 legality limits
      cyc(1'b1, 1, 40);
      check(int'(bad) == 1, "R9 dither with MOD 40", int'(bad), 1);
      cyc(1'b1, 3, 0);
      check(int'(bad) == 0, "R9 no dither with MOD 40", int'(bad), 0);
      cyc(1'b1, 1, 1);
      check(int'(bad) == 1, "R9 MOD 1", int'(bad), 1);
      cyc(1'b1, 1, 50);
      cyc(1'b1, 3, 1);
      check(int'(bad) == 0, "R9 dither with MOD 50", int'(bad), 0);
      cyc(1'b1, 0, 0);
      idle(10);

      $display("  test done: total=%0d bad=%0d", total, nfail);
      $finish;
   end

endmodule